// File: doc/BRIEF.md
# Register and user-memory access with clock write protection

This block sits behind a byte-level serial front end and turns its decoded events (start, stop, received byte, read request) into accesses to two targets: a 48-byte register space and a separate 128-byte user memory. The upper seven bits of the first byte after a start choose the target, and its lowest bit chooses the direction. A write transaction carries a word address and then any number of data bytes. A read transaction streams bytes from the target's current pointer.

The first seven registers hold the time of day. A timekeeping engine updates them through a separate port at any moment. The bus may change them only while an enable bit in a control register is set. To keep a multi-byte time read coherent, the clock registers are copied into a holding buffer when a register read is accepted. Bytes read from 00h to 06h come from that copy until the stop condition.

Each target keeps its own pointer. The pointer survives a stop, so a read that begins without a word address continues where the last access ended. A low level on the bus-enable input (battery backup) makes the block ignore every bus event, and all stored contents are kept.

Top module: `regbank_access`

## Requirements
- R1: A device byte whose bits 7:1 are 1101111 selects the 48-byte register space, and one whose bits 7:1 are 1010111 selects the 128-byte user memory. Bit 0 set to 1 means read and 0 means write, and the two targets keep separate contents.
- R2: In a write transaction, the byte after the device byte loads the target pointer. Each following byte is stored at the pointer, and the pointer then advances by one, so page writes of any length work.
- R3: A bus write to register 00h..06h is stored only while bit 6 of register 08h is 1. Otherwise the byte is dropped, and the pointer still advances.
- R4: Registers 07h..2Fh and every user-memory location accept bus writes regardless of that enable bit.
- R5: Each read request in a read transaction returns the byte at the target pointer on rd_data one cycle later and advances the pointer. The pointer persists across stop, so a read started without a word address continues from the next location.
- R6: The register pointer wraps from 2Fh to 00h, and a word address above 2Fh loads the register pointer with 00h.
- R7: The user-memory pointer wraps from 7Fh to 00h.
- R8: When a register read device byte is accepted, registers 00h..06h are copied into a snapshot. Reads of those addresses return the snapshot until stop, while clock updates keep changing the live registers. A read after the stop returns the updated values.
- R9: tick_we writes tick_data into clock register tick_addr in any state. If a permitted bus write hits the same register in the same cycle, the bus byte is the one kept.
- R10: A device byte that matches neither target makes the block ignore all bytes until the next start. No location and neither pointer changes.
- R11: While bus_en is 0, start, stop, byte and read events have no effect, and all contents and pointers are kept.
- R12: After reset, every register and memory location, both pointers and rd_data are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Serial interface enabled (0 in battery backup) |
| ev_start | input | 1 | Start or repeated start detected |
| ev_stop | input | 1 | Stop detected |
| ev_byte | input | 1 | Received byte valid on rx_byte |
| rx_byte | input | 8 | Received byte |
| ev_rd | input | 1 | Master requests the next read byte |
| rd_data | output | 8 | Byte returned for the last read request |
| tick_we | input | 1 | Timekeeping update strobe |
| tick_addr | input | 3 | Clock register to update |
| tick_data | input | 8 | Clock register value |

## Verification
The bench uses the default parameters: 48 registers, 128 memory bytes, seven clock registers, and the enable in bit 6 of 08h. With these sizes, short random page accesses cross both pointer wraps and the clock/control boundary often. Random writes to 08h switch the write protection on and off in the middle of a run. Timekeeping updates are placed between the bytes of register reads, so the snapshot and the live registers differ while a read is in progress.

// File: rtl/regbank_access.sv
module regbank_access #(
  parameter int REG_DEPTH = 48,
  parameter int MEM_DEPTH = 128,
  parameter int CLK_REGS  = 7,
  parameter int WP_ADDR   = 8,
  parameter int WP_BIT    = 6,
  parameter logic [6:0] REG_DEV = 7'h6F,
  parameter logic [6:0] MEM_DEV = 7'h57
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_en,
  input  logic       ev_start,
  input  logic       ev_stop,
  input  logic       ev_byte,
  input  logic [7:0] rx_byte,
  input  logic       ev_rd,
  output logic [7:0] rd_data,
  input  logic       tick_we,
  input  logic [$clog2(CLK_REGS)-1:0] tick_addr,
  input  logic [7:0] tick_data
);
  localparam int RAW = $clog2(REG_DEPTH);
  localparam int MAW = $clog2(MEM_DEPTH);
  localparam int TAW = $clog2(CLK_REGS);
  localparam logic [RAW-1:0] REG_LAST = RAW'(REG_DEPTH - 1);
  localparam logic [MAW-1:0] MEM_LAST = MAW'(MEM_DEPTH - 1);
  localparam logic [RAW-1:0] CLK_END  = RAW'(CLK_REGS);
  localparam logic [7:0]     REG_LIM  = 8'(REG_DEPTH);

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_ADDR, S_WDAT, S_RDAT} state_t;

  state_t         state;
  logic           tgt_mem;
  logic           snap_on;
  logic [RAW-1:0] reg_ptr;
  logic [MAW-1:0] mem_ptr;
  logic [7:0]     regs [REG_DEPTH];
  logic [7:0]     mem  [MEM_DEPTH];
  logic [CLK_REGS-1:0][7:0] snap;

  wire act      = bus_en && !ev_start && !ev_stop;
  wire hit_reg  = rx_byte[7:1] == REG_DEV;
  wire hit_mem  = rx_byte[7:1] == MEM_DEV;
  wire wp_open  = regs[WP_ADDR][WP_BIT];
  wire in_clk   = reg_ptr < CLK_END;
  wire tick_ok  = tick_we && ({{(RAW-TAW){1'b0}}, tick_addr} < CLK_END);
  wire snap_ld  = act && state == S_DEV && ev_byte && hit_reg && rx_byte[0];

  logic [RAW-1:0] reg_nxt;
  logic [MAW-1:0] mem_nxt;
  logic [7:0]     rd_reg;
  assign reg_nxt = (reg_ptr == REG_LAST) ? '0 : reg_ptr + 1'b1;
  assign mem_nxt = (mem_ptr == MEM_LAST) ? '0 : mem_ptr + 1'b1;
  assign rd_reg  = (snap_on && in_clk) ? snap[reg_ptr[TAW-1:0]] : regs[reg_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      tgt_mem <= 1'b0;
      snap_on <= 1'b0;
      reg_ptr <= '0;
      mem_ptr <= '0;
      rd_data <= '0;
      snap    <= '0;
      for (int i = 0; i < REG_DEPTH; i++) regs[i] <= '0;
      for (int i = 0; i < MEM_DEPTH; i++) mem[i]  <= '0;
    end else begin
      if (tick_ok) regs[tick_addr] <= tick_data;
      if (!bus_en) begin
        state   <= S_IDLE;
        snap_on <= 1'b0;
      end else if (ev_start) begin
        state <= S_DEV;
      end else if (ev_stop) begin
        state   <= S_IDLE;
        snap_on <= 1'b0;
      end else begin
        case (state)
          S_DEV: if (ev_byte) begin
            if (hit_reg || hit_mem) begin
              tgt_mem <= hit_mem;
              state   <= rx_byte[0] ? S_RDAT : S_ADDR;
              if (snap_ld) begin
                snap_on <= 1'b1;
                for (int i = 0; i < CLK_REGS; i++) snap[i] <= regs[i];
              end
            end else begin
              state <= S_IDLE;
            end
          end
          S_ADDR: if (ev_byte) begin
            if (tgt_mem) mem_ptr <= rx_byte[MAW-1:0];
            else         reg_ptr <= (rx_byte < REG_LIM) ? rx_byte[RAW-1:0] : '0;
            state <= S_WDAT;
          end
          S_WDAT: if (ev_byte) begin
            if (tgt_mem) begin
              mem[mem_ptr] <= rx_byte;
              mem_ptr      <= mem_nxt;
            end else begin
              if (!in_clk || wp_open) regs[reg_ptr] <= rx_byte;
              reg_ptr <= reg_nxt;
            end
          end
          S_RDAT: if (ev_rd) begin
            if (tgt_mem) begin
              rd_data <= mem[mem_ptr];
              mem_ptr <= mem_nxt;
            end else begin
              rd_data <= rd_reg;
              reg_ptr <= reg_nxt;
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  // R3
  clk_wp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act && state == S_WDAT && ev_byte && !tgt_mem && in_clk && !wp_open && !tick_we)
    |=> regs[$past(reg_ptr)] == $past(regs[reg_ptr]));

  // R6
  reg_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act && state == S_RDAT && ev_rd && !tgt_mem && reg_ptr == REG_LAST) |=> reg_ptr == '0);

  // R7
  mem_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act && (state == S_RDAT && ev_rd || state == S_WDAT && ev_byte) && tgt_mem
     && mem_ptr == MEM_LAST) |=> mem_ptr == '0);

  // R8
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snap_on && !snap_ld) |=> $stable(snap));

  // R10
  bad_dev_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act && state == S_DEV && ev_byte && !hit_reg && !hit_mem)
    |=> $stable(reg_ptr) && $stable(mem_ptr) && state == S_IDLE);

  // R11
  bus_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_en |=> $stable(reg_ptr) && $stable(mem_ptr) && $stable(rd_data) && !snap_on);
endmodule

// File: tb/test_regbank_access.sv
module test_regbank_access;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] RW = 8'hDE, RR = 8'hDF, MW = 8'hAE, MR = 8'hAF;

  logic clk = 0, rst_n = 0, bus_en = 1;
  logic ev_start = 0, ev_stop = 0, ev_byte = 0, ev_rd = 0, tick_we = 0;
  logic [7:0] rx_byte = 0, tick_data = 0, rd_data;
  logic [2:0] tick_addr = 0;

  int n_run = 0, n_fail = 0;
  logic [7:0] m_regs [48];
  logic [7:0] m_mem  [128];
  logic [7:0] m_snap [7];
  int  p_reg = 0, p_mem = 0;
  bit  m_snap_on = 0;

  regbank_access i_regbank_access (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .ev_start(ev_start), .ev_stop(ev_stop),
    .ev_byte(ev_byte), .rx_byte(rx_byte), .ev_rd(ev_rd), .rd_data(rd_data),
    .tick_we(tick_we), .tick_addr(tick_addr), .tick_data(tick_data));

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  function automatic int nx_reg(int p); return (p == 47) ? 0 : p + 1; endfunction
  function automatic int nx_mem(int p); return (p == 127) ? 0 : p + 1; endfunction
  function automatic logic [7:0] exp_reg(int p);
    return (m_snap_on && p < 7) ? m_snap[p] : m_regs[p];
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic do_start(); ev_start = 1; @(negedge clk); ev_start = 0; endtask
  task automatic do_stop();  ev_stop = 1; @(negedge clk); ev_stop = 0; m_snap_on = 0; endtask
  task automatic send(logic [7:0] b); rx_byte = b; ev_byte = 1; @(negedge clk); ev_byte = 0; endtask
  task automatic rd(output logic [7:0] v); ev_rd = 1; @(negedge clk); ev_rd = 0; v = rd_data; endtask

  task automatic tick(int a, logic [7:0] d);
    tick_we = 1; tick_addr = 3'(a); tick_data = d; @(negedge clk); tick_we = 0;
    m_regs[a] = d;
  endtask

  task automatic model_wr(bit mem, logic [7:0] d);
    if (mem) begin m_mem[p_mem] = d; p_mem = nx_mem(p_mem); end
    else begin
      if (p_reg >= 7 || m_regs[8][6]) m_regs[p_reg] = d;
      p_reg = nx_reg(p_reg);
    end
  endtask

  task automatic wr_txn(bit mem, int addr, int n);
    do_start(); send(mem ? MW : RW); send(8'(addr));
    if (mem) p_mem = addr & 127; else p_reg = (addr < 48) ? addr : 0;
    for (int i = 0; i < n; i++) begin
      logic [7:0] d = 8'($urandom);
      send(d); model_wr(mem, d);
    end
    do_stop();
  endtask

  task automatic rd_txn(bit mem, bit set_addr, int addr, int n, bit ticks, string tag);
    logic [7:0] v;
    do_start();
    if (set_addr) begin
      send(mem ? MW : RW); send(8'(addr));
      if (mem) p_mem = addr & 127; else p_reg = (addr < 48) ? addr : 0;
      do_start();
    end
    send(mem ? MR : RR);
    if (!mem) begin
      for (int i = 0; i < 7; i++) m_snap[i] = m_regs[i];
      m_snap_on = 1;
    end
    for (int i = 0; i < n; i++) begin
      if (ticks) tick($urandom_range(0, 6), 8'($urandom));
      rd(v);
      if (mem) begin chk(tag, v, m_mem[p_mem]); p_mem = nx_mem(p_mem); end
      else begin chk(tag, v, exp_reg(p_reg)); p_reg = nx_reg(p_reg); end
    end
    do_stop();
  endtask

  initial begin
    logic [7:0] v;
    void'($urandom(32'd2024));
    for (int i = 0; i < 48; i++) m_regs[i] = 0;
    for (int i = 0; i < 128; i++) m_mem[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R12 rd_data", rd_data, 8'h00);
    rd_txn(0, 0, 0, 4, 0, "R12 reg reset");
    rd_txn(1, 0, 0, 3, 0, "R12 mem reset");

    // R4: control/alarm regs and memory writable with protection off
    wr_txn(0, 8'h10, 3); rd_txn(0, 1, 8'h10, 3, 0, "R4 reg");
    wr_txn(1, 8'h20, 2); rd_txn(1, 1, 8'h20, 2, 0, "R4 mem");
    // R3: clock regs protected, then opened by bit 6 of 08h
    wr_txn(0, 0, 7); rd_txn(0, 1, 0, 7, 0, "R3 protected");
    do_start(); send(RW); send(8'h08); send(8'h40); do_stop();
    p_reg = 9; m_regs[8] = 8'h40;
    wr_txn(0, 2, 4); rd_txn(0, 1, 0, 9, 0, "R3 enabled");
    // R1/R2: same address in both targets
    wr_txn(0, 5, 1); wr_txn(1, 5, 1);
    rd_txn(0, 1, 5, 1, 0, "R1 reg"); rd_txn(1, 1, 5, 1, 0, "R1 mem");
    wr_txn(1, 8'h40, 6); rd_txn(1, 1, 8'h40, 6, 0, "R2 page");
    // R5: current-address read continues after stop
    rd_txn(0, 1, 8'h0C, 2, 0, "R5 first");
    rd_txn(0, 0, 0, 2, 0, "R5 continue");
    // R6: register wrap and out-of-range address
    wr_txn(0, 8'h2E, 4); rd_txn(0, 1, 8'h2E, 4, 0, "R6 wrap");
    wr_txn(0, 8'h35, 1); rd_txn(0, 1, 8'h00, 1, 0, "R6 over");
    // R7: memory wrap
    wr_txn(1, 8'h7E, 4); rd_txn(1, 1, 8'h7E, 4, 0, "R7 wrap");
    // R8: snapshot during read, live view after stop
    rd_txn(0, 1, 0, 7, 1, "R8 snapshot");
    rd_txn(0, 1, 0, 7, 0, "R8 after stop");
    // R9: same-cycle tick and bus write, bus wins
    do_start(); send(RW); send(8'h03);
    rx_byte = 8'hA5; ev_byte = 1; tick_we = 1; tick_addr = 3; tick_data = 8'h5A;
    @(negedge clk); ev_byte = 0; tick_we = 0;
    m_regs[3] = 8'hA5; p_reg = 4; do_stop();
    tick(1, 8'h77);
    rd_txn(0, 1, 1, 3, 0, "R9 tick and collision");
    // R10: foreign device byte ignored
    rd_txn(0, 1, 8'h20, 1, 0, "R10 setup");
    do_start(); send(8'hA2); send(8'h00); send(8'h99); do_stop();
    rd_txn(0, 0, 0, 2, 0, "R10 ptr kept");
    // R11: bus disabled
    bus_en = 0;
    do_start(); send(RW); send(8'h30); send(8'hEE); ev_rd = 1; @(negedge clk); ev_rd = 0; do_stop();
    bus_en = 1;
    chk("R11 rd_data", rd_data, 8'h00);
    rd_txn(0, 0, 0, 2, 0, "R11 ptr kept");
    rd_txn(0, 1, 8'h30, 1, 0, "R11 contents");

    for (int t = 0; t < 250; t++) begin
      int k = $urandom_range(0, 5);
      case (k)
        0: wr_txn(0, $urandom_range(0, 63), $urandom_range(1, 5));
        1: wr_txn(1, $urandom_range(0, 127), $urandom_range(1, 5));
        2: rd_txn(0, $urandom_range(0, 1), $urandom_range(0, 47), $urandom_range(1, 8), 1, "R5 R8 rnd reg");
        3: rd_txn(1, $urandom_range(0, 1), $urandom_range(0, 127), $urandom_range(1, 6), 0, "R5 R7 rnd mem");
        4: begin
          do_start(); send(RW); send(8'h08);
          v = ($urandom_range(0, 1) != 0) ? 8'h40 : 8'h00;
          send(v); m_regs[8] = v; p_reg = 9; do_stop();
        end
        default: tick($urandom_range(0, 6), 8'($urandom));
      endcase
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule